// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Guard

This block protects one storage word of a FIFO. It sits on both sides of the memory array. On the write side it turns a data word into a codeword. The codeword carries Hamming check bits and one extra bit of overall parity, and it is registered before it goes to the array. On the read side it takes a codeword back from the array, repairs any single flipped bit and detects any pair of flipped bits. It presents the recovered word together with two separate flags, registered in the same cycle as that word.

Two test inputs deliberately damage the codeword as it is written, so that both the repair path and the detection path can be exercised in a system. The single-flip input inverts one fixed codeword bit. The double-flip input inverts two fixed codeword bits. The bit positions are parameters.

Top module: `ecc_word_guard`

## Requirements
- R1: While reset is low, and after it is released until the first operation, `code_valid`, `code_out`, `rd_valid`, `rd_data`, `err_fixed` and `err_fatal` are all zero.
- R2: A write stores its codeword on `code_out`, with `code_valid` high, one clock after `wr_en`. The codeword layout is fixed. Positions 1..N (N = DATA_W + check bits) hold check bits at every power-of-two position. Data bits fill the other positions in ascending order, data bit 0 first. The check bit at position 2^j is the XOR of all other positions whose index has bit j set. Bit 0 makes the XOR of the whole codeword even.
- R3: A write with `inj_one` high and `inj_two` low stores the R2 codeword with exactly bit INJ_POS_A inverted.
- R4: A write with `inj_two` high stores the R2 codeword with exactly bits INJ_POS_A and INJ_POS_B inverted.
- R5: When both inject inputs are high during a write, the double flip of R4 is applied, not the single flip.
- R6: With `wr_en` low, the inject inputs and `wr_data` have no effect: `code_valid` is low and `code_out` holds its previous value.
- R7: A read (`rd_en` high) of an undamaged codeword gives `rd_valid` high, the original data on `rd_data`, and both flags low, one clock later.
- R8: A read of a codeword with any one bit in positions 1..N inverted returns the original data with `err_fixed` high and `err_fatal` low.
- R9: A read of a codeword with only bit 0 inverted returns the data unchanged with `err_fixed` high.
- R10: A read of a codeword with any two bits inverted raises `err_fatal` and keeps `err_fixed` low; the two flags are never high together.
- R11: The flags are registered with `rd_data`. A cycle with `rd_en` low drives `rd_valid` low and holds `rd_data` and both flags.
- R12: An odd overall parity together with a syndrome that points beyond position N (possible only with three or more flips) is reported as `err_fatal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Encode and register `wr_data` this cycle |
| wr_data | input | DATA_W | Data word to protect |
| inj_one | input | 1 | Invert one codeword bit on this write |
| inj_two | input | 1 | Invert two codeword bits on this write (wins over `inj_one`) |
| code_valid | output | 1 | `code_out` was loaded in the previous cycle |
| code_out | output | CODE_W | Registered codeword toward the storage array |
| rd_en | input | 1 | Decode `code_in` this cycle |
| code_in | input | CODE_W | Codeword read from the storage array |
| rd_valid | output | 1 | `rd_data` and flags were loaded in the previous cycle |
| rd_data | output | DATA_W | Recovered data word |
| err_fixed | output | 1 | One flipped bit was found and repaired |
| err_fatal | output | 1 | Uncorrectable damage; `rd_data` is not trustworthy |

## Verification
The bench builds the block with DATA_W = 16, which gives five check bits and a 22-bit codeword. It sets the inject positions to 3 and 12, both of them data positions. Because the codeword is this small, the bench can invert every single position and every pair of positions, 253 cases in all, and so reaches every syndrome value the decoder can produce. Five check bits can also form syndromes above position 21, so a three-bit corruption that aliases past the end of the codeword is within reach as well.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

    // Smallest number of Hamming check bits for a given data width
    function automatic int check_count(input int data_w);
        for (int p = 1; p < 31; p++) begin
            if ((1 << p) >= data_w + p + 1) return p;
        end
        return 31;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHK_W  = check_count(DATA_W),
    parameter int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    function automatic logic [CODE_W-1:0] cover_mask(input int j);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int i = 1; i < CODE_W; i++) m[i] = ((i >> j) & 1) == 1;
        return m;
    endfunction

    function automatic logic [CODE_W-1:0] scatter(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_pow2(i)) begin
                c[i] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    logic [CODE_W-1:0] base_w;
    logic [CHK_W-1:0]  chk_w;
    logic [CODE_W-1:0] full_w;

    assign base_w = scatter(data_i);

    // check bit positions are empty in base_w, so each check covers data only
    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        assign chk_w[j] = ^(base_w & cover_mask(j));
    end

    always_comb begin
        full_w = base_w;
        for (int j = 0; j < CHK_W; j++) full_w[1 << j] = chk_w[j];
    end

    assign code_o = {full_w[CODE_W-1:1], ^full_w[CODE_W-1:1]};

endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
    parameter int CODE_W = 39,
    parameter int POS_A  = 3,
    parameter int POS_B  = 5
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              one_i,
    input  logic              two_i,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] MASK_A = CODE_W'(1) << POS_A;
    localparam logic [CODE_W-1:0] MASK_B = CODE_W'(1) << POS_B;

    logic [CODE_W-1:0] flip_w;

    always_comb begin
        if (two_i)      flip_w = MASK_A | MASK_B;
        else if (one_i) flip_w = MASK_A;
        else            flip_w = '0;
    end

    assign code_o = code_i ^ flip_w;

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHK_W  = check_count(DATA_W),
    parameter int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fixed_o,
    output logic              fatal_o
);

    function automatic logic [CODE_W-1:0] cover_mask(input int j);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int i = 1; i < CODE_W; i++) m[i] = ((i >> j) & 1) == 1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] gather(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_pow2(i)) begin
                d[k] = c[i];
                k++;
            end
        end
        return d;
    endfunction

    logic [CHK_W-1:0]  syn_w;
    logic              odd_w;
    logic              in_rng_w;
    logic [CODE_W-1:0] flip_w;

    for (genvar j = 0; j < CHK_W; j++) begin : g_syn
        assign syn_w[j] = ^(code_i & cover_mask(j));
    end

    assign odd_w    = ^code_i;
    assign in_rng_w = 32'(syn_w) < CODE_W;

    always_comb begin
        flip_w  = '0;
        fixed_o = 1'b0;
        fatal_o = 1'b0;
        if (odd_w) begin
            if (syn_w == '0) begin
                fixed_o = 1'b1;          // only the parity bit was hit
            end else if (in_rng_w) begin
                flip_w[syn_w] = 1'b1;
                fixed_o       = 1'b1;
            end else begin
                fatal_o = 1'b1;          // syndrome past the codeword end
            end
        end else if (syn_w != '0) begin
            fatal_o = 1'b1;
        end
    end

    assign data_o = gather(code_i ^ flip_w);

endmodule

// File: rtl/ecc_word_guard.sv
module ecc_word_guard
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int INJ_POS_A = 3,
    parameter int INJ_POS_B = 5,
    localparam int CHK_W    = check_count(DATA_W),
    localparam int CODE_W   = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_one,
    input  logic              inj_two,
    output logic              code_valid,
    output logic [CODE_W-1:0] code_out,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] code_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_fixed,
    output logic              err_fatal
);

    typedef struct packed {
        logic              cv;
        logic [CODE_W-1:0] cw;
        logic              rv;
        logic [DATA_W-1:0] rd;
        logic              fix;
        logic              fat;
    } guard_st_t;

    logic [CODE_W-1:0] cw_clean;
    logic [CODE_W-1:0] cw_inj;
    logic [DATA_W-1:0] dec_data;
    logic              dec_fix;
    logic              dec_fat;

    guard_st_t st_d, st_q;

    ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_enc (
        .data_i (wr_data),
        .code_o (cw_clean)
    );

    ecc_inject #(.CODE_W(CODE_W), .POS_A(INJ_POS_A), .POS_B(INJ_POS_B)) u_inj (
        .code_i (cw_clean),
        .one_i  (inj_one),
        .two_i  (inj_two),
        .code_o (cw_inj)
    );

    ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_dec (
        .code_i  (code_in),
        .data_o  (dec_data),
        .fixed_o (dec_fix),
        .fatal_o (dec_fat)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cv = wr_en;
        st_d.rv = rd_en;
        if (wr_en) st_d.cw = cw_inj;
        if (rd_en) begin
            st_d.rd  = dec_data;
            st_d.fix = dec_fix;
            st_d.fat = dec_fat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_valid = st_q.cv;
    assign code_out   = st_q.cw;
    assign rd_valid   = st_q.rv;
    assign rd_data    = st_q.rd;
    assign err_fixed  = st_q.fix;
    assign err_fatal  = st_q.fat;

    // injector output against encoder output
    assert_one_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inj_one && !inj_two) |-> ($countones(cw_inj ^ cw_clean) == 1));

    assert_two_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inj_two) |-> ($countones(cw_inj ^ cw_clean) == 2));

    assert_idle_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!code_valid && $stable(code_out)));

    assert_read_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_fixed && err_fatal));

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data) && $stable(err_fixed) && $stable(err_fatal)));

endmodule

// File: tb/test_ecc_word_guard.sv
module test_ecc_word_guard;

    localparam int DW = 16;
    localparam int CW = 22;     // 16 data + 5 check + 1 parity
    localparam int NP = 21;     // highest Hamming position
    localparam int PA = 3;
    localparam int PB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          inj_one = 1'b0;
    logic          inj_two = 1'b0;
    logic          code_valid;
    logic [CW-1:0] code_out;
    logic          rd_en = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          err_fixed;
    logic          err_fatal;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ecc_word_guard #(.DATA_W(DW), .INJ_POS_A(PA), .INJ_POS_B(PB)) i_ecc_word_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .inj_one(inj_one), .inj_two(inj_two), .code_valid(code_valid),
        .code_out(code_out), .rd_en(rd_en), .code_in(code_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_fixed(err_fixed),
        .err_fatal(err_fatal)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference encoder built from the layout rule
    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int k;
        logic par;
        c = '0;
        k = 0;
        for (int i = 1; i <= NP; i++) begin
            if ((i & (i - 1)) != 0) begin
                c[i] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 5; j++) begin
            par = 1'b0;
            for (int i = 1; i <= NP; i++) begin
                if (((i >> j) & 1) == 1 && i != (1 << j)) par ^= c[i];
            end
            c[1 << j] = par;
        end
        c[0] = ^c[NP:1];
        return c;
    endfunction

    task automatic do_write(input logic [DW-1:0] d, input logic a, input logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; inj_one = a; inj_two = b;
        @(negedge clk);
        wr_en = 1'b0; inj_one = 1'b0; inj_two = 1'b0;
    endtask

    task automatic do_read(input logic [CW-1:0] c);
        @(negedge clk);
        rd_en = 1'b1; code_in = c;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(!code_valid && code_out == '0, "R1 write side", {code_valid, code_out}, 0);
        chk(!rd_valid && rd_data == '0 && !err_fixed && !err_fatal, "R1 read side",
            {rd_valid, rd_data, err_fixed, err_fatal}, 0);
    endtask

    task automatic t_encode();
        logic [DW-1:0] pats [5] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0001, 16'h8000};
        foreach (pats[p]) begin
            do_write(pats[p], 1'b0, 1'b0);
            chk(code_valid && code_out == ref_enc(pats[p]), "R2 encode", code_out, ref_enc(pats[p]));
        end
    endtask

    task automatic t_inject_single();
        logic [CW-1:0] e;
        e = ref_enc(16'h3C5A) ^ (CW'(1) << PA);
        do_write(16'h3C5A, 1'b1, 1'b0);
        chk(code_out == e, "R3 single inject", code_out, e);
        do_read(code_out);
        chk(rd_data == 16'h3C5A && err_fixed && !err_fatal, "R8 inject repaired",
            {rd_data, err_fixed, err_fatal}, {16'h3C5A, 2'b10});
    endtask

    task automatic t_inject_double();
        logic [CW-1:0] e;
        e = ref_enc(16'h1234) ^ (CW'(1) << PA) ^ (CW'(1) << PB);
        do_write(16'h1234, 1'b0, 1'b1);
        chk(code_out == e, "R4 double inject", code_out, e);
        do_read(code_out);
        chk(err_fatal && !err_fixed, "R10 inject detected", {err_fixed, err_fatal}, 2'b01);
    endtask

    task automatic t_inject_both();
        logic [CW-1:0] e;
        e = ref_enc(16'hBEEF) ^ (CW'(1) << PA) ^ (CW'(1) << PB);
        do_write(16'hBEEF, 1'b1, 1'b1);
        chk(code_out == e, "R5 double wins", code_out, e);
    endtask

    task automatic t_inject_idle();
        logic [CW-1:0] held;
        do_write(16'h0F0F, 1'b0, 1'b0);
        held = code_out;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'hFFFF; inj_one = 1'b1; inj_two = 1'b1;
        @(negedge clk);
        chk(!code_valid && code_out == held, "R6 idle inject", {code_valid, code_out}, {1'b0, held});
        inj_one = 1'b0; inj_two = 1'b0;
    endtask

    task automatic t_clean_read();
        logic [DW-1:0] pats [3] = '{16'h0000, 16'hFFFF, 16'h6D29};
        foreach (pats[p]) begin
            do_read(ref_enc(pats[p]));
            chk(rd_valid && rd_data == pats[p] && !err_fixed && !err_fatal, "R7 clean read",
                {rd_valid, rd_data, err_fixed, err_fatal}, {1'b1, pats[p], 2'b00});
        end
    endtask

    task automatic t_sweep_single();
        logic [CW-1:0] base;
        base = ref_enc(16'hC3A5);
        for (int i = 1; i <= NP; i++) begin
            do_read(base ^ (CW'(1) << i));
            chk(rd_data == 16'hC3A5 && err_fixed && !err_fatal, "R8 single flip",
                {rd_data, err_fixed, err_fatal}, {16'hC3A5, 2'b10});
        end
    endtask

    task automatic t_parity_only();
        do_read(ref_enc(16'h5A5A) ^ CW'(1));
        chk(rd_data == 16'h5A5A && err_fixed && !err_fatal, "R9 parity bit",
            {rd_data, err_fixed, err_fatal}, {16'h5A5A, 2'b10});
    endtask

    task automatic t_sweep_double();
        logic [CW-1:0] base;
        base = ref_enc(16'h9E37);
        for (int i = 0; i < CW; i++) begin
            for (int j = i + 1; j < CW; j++) begin
                do_read(base ^ (CW'(1) << i) ^ (CW'(1) << j));
                chk(err_fatal && !err_fixed, "R10 pair flip", {err_fixed, err_fatal}, 2'b01);
            end
        end
    endtask

    task automatic t_read_hold();
        do_read(ref_enc(16'h4411) ^ (CW'(1) << 7));
        @(negedge clk);
        rd_en = 1'b0; code_in = ref_enc(16'h0000) ^ (CW'(1) << 2) ^ (CW'(1) << 9);
        @(negedge clk);
        chk(!rd_valid && rd_data == 16'h4411 && err_fixed && !err_fatal, "R11 hold",
            {rd_valid, rd_data, err_fixed, err_fatal}, {1'b0, 16'h4411, 2'b10});
    endtask

    task automatic t_alias();
        // syndrome 16^4^2 = 22 > 21 with odd parity
        do_read(ref_enc(16'h7777) ^ (CW'(1) << 16) ^ (CW'(1) << 4) ^ (CW'(1) << 2));
        chk(err_fatal && !err_fixed, "R12 syndrome out of range", {err_fixed, err_fatal}, 2'b01);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encode();
        t_inject_single();
        t_inject_double();
        t_inject_both();
        t_inject_idle();
        t_clean_read();
        t_sweep_single();
        t_parity_only();
        t_sweep_double();
        t_read_hold();
        t_alias();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule